// File: doc/BRIEF.md
# NAND Hamming Parity Generator

This block watches the data path between a host and a NAND flash device and builds a 24-bit Hamming code over each 512-byte chunk as the bytes go by. Software sets it up through three word registers: a control register that clears the result, a config register that arms the engine and picks which chip select and bus width to follow, and a read-only result register. Once the chunk has passed, software reads the code. It either stores the code in the spare area on a program, or compares it with the stored code on a read.

The code is split into two 12-bit parity groups. Every data bit in the chunk has a 12-bit position: the byte index in the upper nine bits and the bit index in the lower three. For each position bit, one group holds the parity of the data bits whose position has that bit set, and the other group holds the parity of the data bits whose position has that bit clear. The parities are not inverted, so an erased chunk produces zero. When two codes differ by one flipped data bit, the XOR of their set-bit groups gives the location of that bit.

Top module: `nand_hecc_top`

## Requirements
- R1: After a full chunk, bit k of the upper group equals the XOR of all data bits whose 12-bit position {byte index[8:0], bit index[2:0]} has bit k set. Bit k of the lower group equals the XOR of all data bits whose position has bit k clear.
- R2: The result register (word address 2) carries the upper group in bits [27:16] and the lower group in bits [11:0]. Every other bit reads as zero.
- R3: A chunk made only of 0xFF bytes yields a result word of zero.
- R4: The config register (word address 1) holds enable in bit 0, the followed chip-select number in bits [3:1] and the bus width in bit 7 (1 = 16-bit). It reads back exactly those fields, and every other bit reads as zero.
- R5: A tap beat feeds the accumulator only when the engine is enabled and tap_cs equals the configured chip select. Beats on other chip selects leave the result unchanged.
- R6: Writing the config register with zero stops accumulation. Beats that follow leave the result unchanged.
- R7: A write to the control register (word address 0) with bit 8 set clears the result, the byte count and the done flag, and sets the slot field, control read bits [3:0], to 1.
- R8: ecc_done rises once 512 bytes have been accumulated. After that, further beats are ignored and the result holds until the next clear.
- R9: In 16-bit mode, each beat supplies two bytes. tap_data[7:0] takes the even byte index and tap_data[15:8] the next one, so the code matches the code of the same byte stream sent in 8-bit mode.
- R10: For two chunks that differ in one data bit, the XOR of their result words has the flipped bit's position in bits [27:16] and the complement of that position in bits [11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 config, 2 result |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tap_valid | input | 1 | A data beat is on the NAND data path this cycle |
| tap_cs | input | 3 | Chip select of the beat |
| tap_data | input | 16 | Beat data; only [7:0] is used in 8-bit mode |
| ecc_done | output | 1 | A full chunk has been accumulated |

## Verification
The checks assume the following about the inputs:
- Register writes are single-cycle strobes.
- At most one tap beat arrives per cycle.
- A clear write arrives between chunks, not in the middle of one.

The stimulus follows these rules:
- Every chunk starts with a clear.
- Beats for other chip selects are interleaved with the wanted beats, never overlapping them.
- The bus width changes only right after a clear.

With the width changing only after a clear, a 16-bit chunk always starts at an even byte index.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;

  localparam int unsigned BIT_IDX_W = 3;

  // Register word addresses
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_CFG    = 2'd1;
  localparam logic [1:0] ADDR_RESULT = 2'd2;

  // Field positions
  localparam int unsigned CLR_BIT   = 8;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned CS_LSB    = 1;
  localparam int unsigned WIDE_BIT  = 7;
  localparam int unsigned UPPER_LSB = 16;

  // Parity of the bits of one byte whose bit index has bit m set (up) or clear (lo)
  function automatic logic [BIT_IDX_W-1:0] bitpos_par(input logic [7:0] d, input logic want_set);
    logic [BIT_IDX_W-1:0] acc;
    acc = '0;
    for (int m = 0; m < BIT_IDX_W; m++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> m) & 1) == (want_set ? 1 : 0)) acc[m] = acc[m] ^ d[b];
      end
    end
    return acc;
  endfunction

endpackage

// File: rtl/nand_hecc_regs.sv
module nand_hecc_regs
  import nand_hecc_pkg::*;
#(
  parameter int unsigned CS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic            cfg_en,
  output logic [CS_W-1:0] cfg_cs,
  output logic            cfg_wide,
  output logic            clr_pulse,
  output logic [3:0]      slot
);

  logic            en_d, wide_d;
  logic [CS_W-1:0] cs_d;
  logic [3:0]      slot_d;
  logic            cfg_we, ctrl_we;

  assign cfg_we    = reg_wr && (reg_addr == ADDR_CFG);
  assign ctrl_we   = reg_wr && (reg_addr == ADDR_CTRL);
  assign clr_pulse = ctrl_we && reg_wdata[CLR_BIT];

  always_comb begin
    en_d   = cfg_en;
    cs_d   = cfg_cs;
    wide_d = cfg_wide;
    slot_d = slot;
    if (cfg_we) begin
      en_d   = reg_wdata[EN_BIT];
      cs_d   = reg_wdata[CS_LSB +: CS_W];
      wide_d = reg_wdata[WIDE_BIT];
    end
    if (clr_pulse) slot_d = 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en   <= 1'b0;
      cfg_cs   <= '0;
      cfg_wide <= 1'b0;
      slot     <= '0;
    end else begin
      cfg_en   <= en_d;
      cfg_cs   <= cs_d;
      cfg_wide <= wide_d;
      slot     <= slot_d;
    end
  end

endmodule

// File: rtl/nand_hecc_lane.sv
module nand_hecc_lane
  import nand_hecc_pkg::*;
#(
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned HALF_W = IDX_W + BIT_IDX_W
) (
  input  logic              lane_en,
  input  logic [7:0]        lane_byte,
  input  logic [IDX_W-1:0]  lane_idx,
  output logic [HALF_W-1:0] lane_up,
  output logic [HALF_W-1:0] lane_lo
);

  logic byte_par;
  assign byte_par = ^lane_byte;

  always_comb begin
    lane_up = '0;
    lane_lo = '0;
    if (lane_en) begin
      lane_up[BIT_IDX_W-1:0] = bitpos_par(lane_byte, 1'b1);
      lane_lo[BIT_IDX_W-1:0] = bitpos_par(lane_byte, 1'b0);
      for (int k = 0; k < IDX_W; k++) begin
        lane_up[BIT_IDX_W+k] = byte_par &  lane_idx[k];
        lane_lo[BIT_IDX_W+k] = byte_par & ~lane_idx[k];
      end
    end
  end

endmodule

// File: rtl/nand_hecc_accum.sv
module nand_hecc_accum
  import nand_hecc_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 512,
  parameter int unsigned IDX_W       = $clog2(CHUNK_BYTES),
  parameter int unsigned HALF_W      = IDX_W + BIT_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              beat_ok,
  input  logic              wide,
  input  logic [15:0]       beat_data,
  output logic [HALF_W-1:0] up_q,
  output logic [HALF_W-1:0] lo_q,
  output logic              done
);

  localparam int unsigned CNT_W = IDX_W + 1;
  localparam int unsigned LANES = 2;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HALF_W-1:0] up_d, lo_d;
  logic [LANES-1:0]  lane_en;
  logic [HALF_W-1:0] lane_up [LANES];
  logic [HALF_W-1:0] lane_lo [LANES];
  logic [CNT_W-1:0]  next_idx;

  assign done     = (cnt_q == CNT_W'(CHUNK_BYTES));
  assign next_idx = cnt_q + CNT_W'(1);

  assign lane_en[0] = beat_ok && !done;
  assign lane_en[1] = beat_ok && !done && wide && (next_idx < CNT_W'(CHUNK_BYTES));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CNT_W-1:0] idx_full;
    assign idx_full = cnt_q + CNT_W'(g);
    nand_hecc_lane #(
      .IDX_W  (IDX_W),
      .HALF_W (HALF_W)
    ) u_lane (
      .lane_en   (lane_en[g]),
      .lane_byte (beat_data[8*g +: 8]),
      .lane_idx  (idx_full[IDX_W-1:0]),
      .lane_up   (lane_up[g]),
      .lane_lo   (lane_lo[g])
    );
  end

  always_comb begin
    up_d  = up_q;
    lo_d  = lo_q;
    cnt_d = cnt_q;
    if (clr) begin
      up_d  = '0;
      lo_d  = '0;
      cnt_d = '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        up_d  = up_d ^ lane_up[l];
        lo_d  = lo_d ^ lane_lo[l];
        cnt_d = cnt_d + CNT_W'(lane_en[l]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= '0;
      lo_q  <= '0;
      cnt_q <= '0;
    end else begin
      up_q  <= up_d;
      lo_q  <= lo_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/nand_hecc_top.sv
module nand_hecc_top
  import nand_hecc_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 512,
  parameter int unsigned CS_W        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            tap_valid,
  input  logic [CS_W-1:0] tap_cs,
  input  logic [15:0]     tap_data,
  output logic            ecc_done
);

  localparam int unsigned IDX_W  = $clog2(CHUNK_BYTES);
  localparam int unsigned HALF_W = IDX_W + BIT_IDX_W;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              cfg_en, cfg_wide, clr_pulse, beat_ok;
  logic [CS_W-1:0]   cfg_cs;
  logic [3:0]        slot;
  logic [HALF_W-1:0] up_q, lo_q;
  logic [31:0]       code_word, cfg_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  nand_hecc_regs #(.CS_W(CS_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cfg_en    (cfg_en),
    .cfg_cs    (cfg_cs),
    .cfg_wide  (cfg_wide),
    .clr_pulse (clr_pulse),
    .slot      (slot)
  );

  assign beat_ok = tap_valid && cfg_en && (tap_cs == cfg_cs);

  nand_hecc_accum #(
    .CHUNK_BYTES (CHUNK_BYTES),
    .IDX_W       (IDX_W),
    .HALF_W      (HALF_W)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (clr_pulse),
    .beat_ok   (beat_ok),
    .wide      (cfg_wide),
    .beat_data (tap_data),
    .up_q      (up_q),
    .lo_q      (lo_q),
    .done      (ecc_done)
  );

  always_comb begin
    code_word = '0;
    code_word[UPPER_LSB +: HALF_W] = up_q;
    code_word[0 +: HALF_W]         = lo_q;
    cfg_word = '0;
    cfg_word[EN_BIT]           = cfg_en;
    cfg_word[CS_LSB +: CS_W]   = cfg_cs;
    cfg_word[WIDE_BIT]         = cfg_wide;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:   reg_rdata = {28'd0, slot};
      ADDR_CFG:    reg_rdata = cfg_word;
      ADDR_RESULT: reg_rdata = code_word;
      default:     reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/nand_hecc_chk.sv
module nand_hecc_chk #(
  parameter int unsigned CS_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [1:0]      reg_addr,
  input logic [31:0]     reg_wdata,
  input logic            tap_valid,
  input logic [CS_W-1:0] tap_cs,
  input logic            cfg_en,
  input logic [CS_W-1:0] cfg_cs,
  input logic [31:0]     code_word,
  input logic            ecc_done
);

  logic clr_wr;
  assign clr_wr = reg_wr && (reg_addr == 2'd0) && reg_wdata[8];

  // R2
  field_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_word & 32'hF000_F000) == 32'd0);

  // R7
  clear_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (code_word == 32'd0) && !ecc_done);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_done && !clr_wr) |=> ecc_done && $stable(code_word));

  // R5
  other_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_valid && (tap_cs != cfg_cs) && !clr_wr) |=> $stable(code_word));

  // R6
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !clr_wr) |=> $stable(code_word));

endmodule

bind nand_hecc_top nand_hecc_chk #(.CS_W(CS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .tap_valid (tap_valid),
  .tap_cs    (tap_cs),
  .cfg_en    (cfg_en),
  .cfg_cs    (cfg_cs),
  .code_word (code_word),
  .ecc_done  (ecc_done)
);

// File: tb/nand_hecc_top_tb.sv
module nand_hecc_top_tb;

  localparam int N = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        tap_valid;
  logic [2:0]  tap_cs;
  logic [15:0] tap_data;
  logic        ecc_done;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  logic [31:0] exp_q[$];
  logic [7:0]  buf_a [N];
  logic [7:0]  buf_b [N];
  logic [31:0] code_b, code_c, r1;

  always #4 clk = ~clk;

  nand_hecc_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tap_valid(tap_valid),
    .tap_cs(tap_cs), .tap_data(tap_data), .ecc_done(ecc_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // model of the code from the requirement text
  function automatic logic [31:0] model(input logic [7:0] d [N]);
    logic [11:0] up = '0, lo = '0;
    for (int i = 0; i < N; i++)
      for (int b = 0; b < 8; b++)
        if (d[i][b]) begin
          logic [11:0] pos = {i[8:0], b[2:0]};
          for (int k = 0; k < 12; k++)
            if (pos[k]) up[k] = ~up[k]; else lo[k] = ~lo[k];
        end
    return {4'd0, up, 4'd0, lo};
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic beat(input logic [2:0] cs, input logic [15:0] d);
    @(negedge clk);
    tap_valid = 1'b1; tap_cs = cs; tap_data = d;
    @(negedge clk);
    tap_valid = 1'b0;
  endtask

  // driver: sends bytes [from, to) and pushes the expected code for the scoreboard
  task automatic drive(input logic [7:0] d [N], input int from, input int to,
                       input bit wide, input bit noise);
    for (int i = from; i < to; i += (wide ? 2 : 1)) begin
      if (noise && (i % 7 == 0)) beat(3'd5, 16'h5A5A);
      if (wide) beat(3'd2, {d[i+1], d[i]});
      else      beat(3'd2, {8'h00, d[i]});
    end
  endtask

  // monitor: reads the result and compares with the head of the queue
  task automatic monitor(input string req, output logic [31:0] got);
    logic [31:0] e;
    rd_reg(2'd2, got);
    e = exp_q.pop_front();
    check(req, got, e);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    tap_valid = 0; tap_cs = 0; tap_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    rd_reg(2'd2, v); check("R7 reset result", v, 32'd0);
    check("R8 reset done", {31'd0, ecc_done}, 32'd0);
    rd_reg(2'd1, v); check("R4 reset cfg", v, 32'd0);

    wr_reg(2'd1, 32'hFFFF_FF05 & ~32'h80); // en=1, cs=2, narrow; junk in other bits
    rd_reg(2'd1, v); check("R4 cfg readback", v, 32'h0000_0005);
    wr_reg(2'd0, 32'h100);
    rd_reg(2'd0, v); check("R7 slot after clear", v, 32'd1);

    // R3: erased chunk
    for (int i = 0; i < N; i++) buf_a[i] = 8'hFF;
    exp_q.push_back(32'd0);
    drive(buf_a, 0, N, 0, 0);
    check("R8 done after chunk", {31'd0, ecc_done}, 32'd1);
    monitor("R3 erased chunk", v);

    wr_reg(2'd0, 32'h100);
    rd_reg(2'd2, v); check("R7 clear result", v, 32'd0);
    check("R7 clear done", {31'd0, ecc_done}, 32'd0);

    // R1 + R5: random chunk with beats on another chip select mixed in
    for (int i = 0; i < N; i++) buf_b[i] = 8'($urandom);
    exp_q.push_back(model(buf_b));
    drive(buf_b, 0, N, 0, 1);
    monitor("R1 R5 random chunk", code_b);
    check("R2 unused bits zero", code_b & 32'hF000_F000, 32'd0);
    for (int i = 0; i < 10; i++) beat(3'd2, 16'h00A7);
    rd_reg(2'd2, v); check("R8 bytes after done ignored", v, code_b);

    // R10: single flipped bit at byte 300 bit 5
    for (int i = 0; i < N; i++) buf_a[i] = buf_b[i];
    buf_a[300][5] = ~buf_a[300][5];
    wr_reg(2'd0, 32'h100);
    exp_q.push_back(model(buf_a));
    drive(buf_a, 0, N, 0, 0);
    monitor("R1 flipped chunk", code_c);
    check("R10 syndrome", code_b ^ code_c,
          {4'd0, 12'((300 << 3) | 5), 4'd0, ~12'((300 << 3) | 5)});

    // R9: 16-bit mode, same stream
    wr_reg(2'd1, 32'h85);
    wr_reg(2'd0, 32'h100);
    exp_q.push_back(code_b);
    drive(buf_b, 0, N, 1, 1);
    check("R9 done in wide mode", {31'd0, ecc_done}, 32'd1);
    monitor("R9 wide equals narrow", v);

    // R6: partial chunk, then config zero
    wr_reg(2'd1, 32'h05);
    wr_reg(2'd0, 32'h100);
    for (int i = 0; i < N; i++) buf_a[i] = (i < 100) ? buf_b[i] : 8'h00;
    exp_q.push_back(model(buf_a));
    drive(buf_b, 0, 100, 0, 0);
    monitor("R1 partial chunk", r1);
    wr_reg(2'd1, 32'h0);
    drive(buf_b, 100, 150, 0, 0);
    rd_reg(2'd2, v); check("R6 disabled holds result", v, r1);
    check("R6 done stays low", {31'd0, ecc_done}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule